// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block sits between a simple synchronous request port and an external asynchronous static RAM of 131,072 bytes. A client presents a request with a write flag, a 17-bit word address and a byte of write data while `ready` is high. The block then sequences the two chip selects (one active low, one active high), the output-enable and write-enable strobes, the address lines and a shared, tri-stated 8-bit data bus. It returns a one-cycle `done` pulse when the access finishes. For reads, the byte it captured is presented on `rdata` in the same cycle as `done`.

Every analog timing limit of the memory is turned into a whole number of system clocks. Each limit in nanoseconds is divided by the clock period and rounded up. Every access begins with one clock in which the new address is on the pins and both strobes are inactive. During a write, the data bus is first left undriven long enough for the memory to stop driving it. The block drives the write data only after that, and releases the bus on the same edge on which write-enable returns high.

A low-power retention request deselects the memory and holds it deselected. Once the request is withdrawn, the block waits a full read cycle time before it accepts the next access.

Top module: `sram_async_ctrl`

## Requirements
- R1: A request is accepted only on a clock edge where `req` and `ready` are both high. `ready` is low from the cycle after acceptance until the cycle in which `done` is high.
- R2: After reset, and whenever no access is in progress, the memory is deselected (`sram_ce1_n`=1, `sram_ce2`=0) with `sram_oe_n`=1 and `sram_we_n`=1. `sram_oe_n` and `sram_we_n` are never both low. Either strobe is low only while `sram_ce1_n`=0 and `sram_ce2`=1.
- R3: Every access holds both strobes high for one clock with the new address already on `sram_addr` before either strobe falls. `sram_addr` does not change while `sram_we_n` is low.
- R4: A read holds `sram_oe_n` low for RD cycles, where RD is the ceiling of max(read cycle 35 ns, address access 35 ns, output-enable access 25 ns) divided by the clock period. It captures the bus on the edge that ends that interval. `done` and the captured `rdata` appear 1+RD clock edges after acceptance (3 at 50 MHz).
- R5: A write holds `sram_we_n` low for WZ+WD cycles. WZ is the ceiling of 15 ns (the time for the memory's outputs to turn off) divided by the period. The bus is not driven during those first WZ cycles, and is driven with the write data for the following WD cycles. WD is the largest of: the 20 ns data setup in cycles; the 25 ns pulse width in cycles minus WZ; the 30 ns and 35 ns address-to-end and cycle limits in cycles minus 1+WZ; and 1. The bus is released on the edge where `sram_we_n` rises. `done` appears 1+WZ+WD edges after acceptance (3 at 50 MHz).
- R6: `done` is high for exactly one cycle per completed access, reads and writes alike.
- R7: While `retain_req` is high in an idle cycle, the memory is held deselected and `ready` is low. `retain_req` takes priority over a simultaneous `req`, which is then not accepted and causes no strobe activity.
- R8: After `retain_req` falls, `ready` stays low for RC more clock edges, where RC is the ceiling of 35 ns divided by the period. The memory stays deselected throughout.
- R9: A byte written to any address, including address 0 and address 0x1FFFF, is returned by a later read of that address, across retention periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when ready is high |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address of the access |
| wdata | input | 8 | Byte to write |
| retain_req | input | 1 | Request for low-power retention |
| ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| sram_ce1_n | output | 1 | Memory chip select, active low |
| sram_ce2 | output | 1 | Memory chip select, active high |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | 17 | Memory address lines |
| sram_dq | inout | 8 | Shared memory data bus |

## Verification
The bench aims at the strobe edges. It checks that the address is settled one clock before a strobe falls, that it never moves under a low write strobe, and that the write-enable pulse and the output-enable pulse have exactly the computed lengths. A design that skipped the setup clock, or that let the address move mid-write, would corrupt an unrelated location. A pulse one cycle short would violate the data-setup or access time.

The bench also raises retention together with a request. A design that let the request win would strobe a deselected memory. A design that woke up early would fail the recovery count.

Write and read traffic hits random addresses as well as both ends of the address space. A read right after a write to the same location shows any mix-up between capture and drive.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ,
    ST_WHZ,
    ST_WDRV,
    ST_RETAIN,
    ST_WAKE
  } seq_state_e;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Nanosecond limit to whole clocks, rounded up.
  function automatic int ns_to_clk(int ns, int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int read_clks(int trc, int taa, int toe, int per);
    return imax(1, imax(ns_to_clk(trc, per), imax(ns_to_clk(taa, per), ns_to_clk(toe, per))));
  endfunction

  function automatic int hiz_clks(int twhz, int per);
    return imax(1, ns_to_clk(twhz, per));
  endfunction

  // Driven part of the write pulse; the setup clock and the hi-Z part count towards the limits.
  function automatic int drive_clks(int tdw, int twp, int taw, int twc, int twhz, int per);
    int wz;
    wz = hiz_clks(twhz, per);
    return imax(1, imax(ns_to_clk(tdw, per),
                 imax(ns_to_clk(twp, per) - wz,
                 imax(ns_to_clk(taw, per) - 1 - wz, ns_to_clk(twc, per) - 1 - wz))));
  endfunction

  function automatic int cnt_width(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC = 2,
  parameter int WZ_CYC = 1,
  parameter int WD_CYC = 1,
  parameter int RC_CYC = 2,
  parameter int CNT_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic wr,
  input  logic retain_req,
  output logic ready,
  output logic accept,
  output logic done,
  output logic capture,
  output logic sel,
  output logic oe_n,
  output logic we_n,
  output logic drive_en,
  output logic in_retain
);

  seq_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic op_wr_q;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign ready    = (st_q == ST_IDLE) && !retain_req;
  assign accept   = req && ready;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    capture = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (retain_req) st_d = ST_RETAIN;
        else if (req)   st_d = ST_SETUP;
      end
      ST_SETUP: begin
        if (op_wr_q) begin
          st_d  = ST_WHZ;
          cnt_d = CNT_W'(WZ_CYC - 1);
        end else begin
          st_d  = ST_READ;
          cnt_d = CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: begin
        if (cnt_zero) begin
          st_d    = ST_IDLE;
          capture = 1'b1;
          done_d  = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_WHZ: begin
        if (cnt_zero) begin
          st_d  = ST_WDRV;
          cnt_d = CNT_W'(WD_CYC - 1);
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_WDRV: begin
        if (cnt_zero) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      ST_RETAIN: begin
        if (!retain_req) begin
          st_d  = ST_WAKE;
          cnt_d = CNT_W'(RC_CYC - 1);
        end
      end
      ST_WAKE: begin
        if (cnt_zero) st_d = ST_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      op_wr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      if (accept) op_wr_q <= wr;
    end
  end

  // Strobes decoded from the state register only.
  assign sel       = (st_q == ST_SETUP) || (st_q == ST_READ) || (st_q == ST_WHZ) || (st_q == ST_WDRV);
  assign oe_n      = (st_q != ST_READ);
  assign we_n      = !((st_q == ST_WHZ) || (st_q == ST_WDRV));
  assign drive_en  = (st_q == ST_WDRV);
  assign in_retain = (st_q == ST_RETAIN);
  assign done      = done_q;

endmodule

// File: rtl/sram_bus_port.sv
module sram_bus_port #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              capture,
  input  logic              drive_en,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        addr_q  <= addr_in;
        wdata_q <= wdata_in;
      end
      if (capture) rdata_q <= sram_dq;
    end
  end

  assign sram_addr = addr_q;
  assign rdata     = rdata_q;
  assign sram_dq   = drive_en ? wdata_q : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int T_RC_NS       = 35,
  parameter int T_AA_NS       = 35,
  parameter int T_OE_NS       = 25,
  parameter int T_WC_NS       = 35,
  parameter int T_AW_NS       = 30,
  parameter int T_WP_NS       = 25,
  parameter int T_DW_NS       = 20,
  parameter int T_WHZ_NS      = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              retain_req,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              sram_ce1_n,
  output logic              sram_ce2,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [ADDR_W-1:0] sram_addr,
  inout  wire  [DATA_W-1:0] sram_dq
);

  localparam int RD_CYC = read_clks(T_RC_NS, T_AA_NS, T_OE_NS, CLK_PERIOD_NS);
  localparam int WZ_CYC = hiz_clks(T_WHZ_NS, CLK_PERIOD_NS);
  localparam int WD_CYC = drive_clks(T_DW_NS, T_WP_NS, T_AW_NS, T_WC_NS, T_WHZ_NS, CLK_PERIOD_NS);
  localparam int RC_CYC = imax(1, ns_to_clk(T_RC_NS, CLK_PERIOD_NS));
  localparam int CNT_W  = cnt_width(imax(imax(RD_CYC, RC_CYC), imax(WZ_CYC, WD_CYC)));

  // Named internal events, also observed by the checker.
  logic accept;
  logic capture;
  logic sel;
  logic bus_drive;
  logic in_retain;

  sram_seq_fsm #(
    .RD_CYC(RD_CYC), .WZ_CYC(WZ_CYC), .WD_CYC(WD_CYC), .RC_CYC(RC_CYC), .CNT_W(CNT_W)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .retain_req(retain_req),
    .ready(ready), .accept(accept), .done(done), .capture(capture), .sel(sel),
    .oe_n(sram_oe_n), .we_n(sram_we_n), .drive_en(bus_drive), .in_retain(in_retain)
  );

  sram_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
    .clk(clk), .rst_n(rst_n), .load(accept), .capture(capture), .drive_en(bus_drive),
    .addr_in(addr), .wdata_in(wdata), .rdata(rdata), .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  assign sram_ce1_n = !sel;
  assign sram_ce2   = sel;

endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              done,
  input logic              accept,
  input logic              bus_drive,
  input logic              in_retain,
  input logic              sram_ce1_n,
  input logic              sram_ce2,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic [ADDR_W-1:0] sram_addr
);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ready);

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n || !sram_oe_n) |-> (!sram_ce1_n && sram_ce2));

  a_r3_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (sram_we_n && sram_oe_n));

  a_r3_addr_held_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> $stable(sram_addr));

  a_r5_no_drive_at_we_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> !bus_drive);

  a_r5_release_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> !bus_drive);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_retain_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    in_retain |-> (sram_ce1_n && !sram_ce2 && !ready));

endmodule

bind sram_async_ctrl sram_ctrl_checker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .done(done), .accept(accept),
  .bus_drive(bus_drive), .in_retain(in_retain), .sram_ce1_n(sram_ce1_n),
  .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_addr(sram_addr)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;

  localparam int PER = 20;

  // Bench's own restatement of the cycle counts: smallest n with n*PER >= ns.
  function automatic int clks(int ns);
    int n = 0;
    while (n * PER < ns) n++;
    return n;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_RD = mx(clks(35), clks(25));
  localparam int B_WZ = mx(1, clks(15));
  localparam int B_WD = mx(1, mx(clks(20), mx(clks(25) - B_WZ, mx(clks(30) - 1 - B_WZ, clks(35) - 1 - B_WZ))));
  localparam int B_RC = clks(35);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, retain_req = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0] wdata = '0;
  logic ready, done;
  logic [7:0] rdata;
  logic sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n;
  logic [16:0] sram_addr;
  wire  [7:0] sram_dq;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_async_ctrl i_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .retain_req(retain_req), .ready(ready), .done(done), .rdata(rdata),
    .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_addr(sram_addr), .sram_dq(sram_dq)
  );

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [int];
  logic [7:0] mdata = 8'hA5;
  logic [7:0] pend = '0;
  logic [16:0] pend_addr = '0;
  wire mdrv = !sram_ce1_n && sram_ce2 && !sram_oe_n && sram_we_n;
  assign sram_dq = mdrv ? mdata : 8'hzz;

  int we_lo = 0, oe_lo = 0;
  logic prev_we = 1'b1, prev_oe = 1'b1;
  logic [16:0] prev_addr = '0;

  task automatic fail(string req_tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
  endtask

  always @(negedge clk) begin
    mdata <= mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 8'hA5;
    if (rst_n) begin
      if (!sram_we_n && !sram_oe_n) begin checks++; fail("R2", "both strobes low (contention risk)", 0, 1); end
      if ((!sram_we_n || !sram_oe_n) && !(!sram_ce1_n && sram_ce2)) begin
        checks++; fail("R2", "strobe low while deselected", 0, 1);
      end
      if (!sram_we_n && !prev_we && sram_addr != prev_addr) begin
        checks++; fail("R3", "address moved under low write strobe", sram_addr, prev_addr);
      end
      // R3: strobe fall needs a preceding clock with same address and both strobes high
      if ((!sram_we_n && prev_we) || (!sram_oe_n && prev_oe)) begin
        checks++;
        if (!(prev_we && prev_oe && prev_addr == sram_addr))
          fail("R3", "no setup clock before strobe", prev_addr, sram_addr);
      end
      if (!sram_we_n) begin
        we_lo = we_lo + 1;
        if (we_lo > B_WZ) begin pend = sram_dq; pend_addr = sram_addr; end
      end else if (!prev_we) begin
        checks++;
        if (we_lo != B_WZ + B_WD) fail("R5", "write strobe length", we_lo, B_WZ + B_WD);
        mem[int'(pend_addr)] = pend;
        we_lo = 0;
      end
      if (!sram_oe_n) oe_lo = oe_lo + 1;
      else if (!prev_oe) begin
        checks++;
        if (oe_lo != B_RD) fail("R4", "read strobe length", oe_lo, B_RD);
        oe_lo = 0;
      end
    end
    prev_we   = sram_we_n;
    prev_oe   = sram_oe_n;
    prev_addr = sram_addr;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          rd;
    logic [7:0]  data;
    int          acc;
    int          lat;
  } exp_t;
  exp_t sb[$];
  logic [7:0] shadow [int];
  bit done_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev) begin
        checks++;
        if (done) fail("R6", "done longer than one cycle", 1, 0);
      end
      if (done) begin
        if (sb.size() == 0) begin checks++; fail("R6", "done without access", 1, 0); end
        else begin
          exp_t e;
          e = sb.pop_front();
          checks++;
          if (cyc - e.acc != e.lat) fail(e.rd ? "R4" : "R5", "done latency", cyc - e.acc, e.lat);
          checks++;
          if (ready !== 1'b1) fail("R1", "ready with done", ready, 1);
          if (e.rd) begin
            checks++;
            if (rdata !== e.data) fail("R9", "read data", rdata, e.data);
          end
        end
      end
      done_prev = done;
    end
  end

  task automatic access(bit is_wr, logic [16:0] a, logic [7:0] d);
    exp_t e;
    while (ready !== 1'b1) @(negedge clk);
    req = 1'b1; wr = is_wr; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    checks++;
    if (ready !== 1'b0) fail("R1", "ready after accept", ready, 0);
    e.rd  = !is_wr;
    e.acc = cyc;
    if (is_wr) begin
      shadow[int'(a)] = d;
      e.data = d;
      e.lat  = 1 + B_WZ + B_WD;
    end else begin
      e.data = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'hA5;
      e.lat  = 1 + B_RD;
    end
    sb.push_back(e);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      checks++;
      fail("ALL", "watchdog expired", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [16:0] tas [20];
  logic [7:0]  tds [20];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset / idle state
    checks++;
    if (!(sram_ce1_n === 1'b1 && sram_ce2 === 1'b0 && sram_oe_n === 1'b1 &&
          sram_we_n === 1'b1 && ready === 1'b1 && done === 1'b0))
      fail("R2", "idle pins after reset", {sram_ce1_n, sram_ce2, sram_oe_n, sram_we_n, ready, done}, 6'b101110);

    // R9: boundary addresses and a read of an unwritten location
    access(1'b0, 17'h00123, 8'h00);
    access(1'b1, 17'h00000, 8'h3C);
    access(1'b1, 17'h1FFFF, 8'hC3);
    access(1'b0, 17'h00000, 8'h00);
    access(1'b0, 17'h1FFFF, 8'h00);

    // R9: random writes then reads, then write/read pairs to the same address
    for (int i = 0; i < 20; i++) begin
      tas[i] = 17'($urandom);
      tds[i] = 8'($urandom);
      access(1'b1, tas[i], tds[i]);
    end
    for (int i = 19; i >= 0; i--) access(1'b0, tas[i], 8'h00);
    for (int i = 0; i < 6; i++) begin
      logic [16:0] a;
      a = 17'($urandom);
      access(1'b1, a, 8'(i * 37 + 5));
      access(1'b0, a, 8'h00);
      access(1'b0, a, 8'h00);
    end

    // R7: retention entry with a competing request
    while (ready !== 1'b1 || sb.size() != 0) @(negedge clk);
    retain_req = 1'b1;
    req = 1'b1; wr = 1'b1; addr = 17'h00005; wdata = 8'hEE;
    @(negedge clk);
    checks++;
    if (!(sram_ce1_n === 1'b1 && sram_ce2 === 1'b0 && ready === 1'b0))
      fail("R7", "retention deselect", {sram_ce1_n, sram_ce2, ready}, 3'b100);
    begin
      bit bad = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (sram_we_n !== 1'b1 || sram_ce1_n !== 1'b1 || ready !== 1'b0) bad = 1;
      end
      checks++;
      if (bad) fail("R7", "request acted on during retention", 1, 0);
    end
    retain_req = 1'b0;
    req = 1'b0;
    // R8: recovery wait
    for (int k = 0; k < B_RC; k++) begin
      @(negedge clk);
      checks++;
      if (ready !== 1'b0 || sram_ce1_n !== 1'b1) fail("R8", "ready during recovery", ready, 0);
    end
    @(negedge clk);
    checks++;
    if (ready !== 1'b1) fail("R8", "ready after recovery", ready, 1);

    // R9: contents survive retention
    access(1'b0, 17'h1FFFF, 8'h00);
    access(1'b0, tas[3], 8'h00);
    access(1'b0, 17'h00005, 8'h00);

    repeat (10) @(negedge clk);
    checks++;
    if (sb.size() != 0) fail("R6", "accesses without done", sb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule